// File: doc/BRIEF.md
# Unsigned Array Multiplier with High-Word Access

This block multiplies two unsigned operands in a purely combinational array and gives a simple processor two ways to reach the double-length product. The array is a column of identical stage cells. The cell for multiplier bit k gates the multiplicand with that bit and adds the gated value into the running partial sum, shifted k places. Bit k of the product is the least significant bit of that stage's sum. A small wrapper puts one word of the product on a single result bus, chosen by an operation code. A held copy of the high word can be read back on a later cycle without repeating the multiply.

The processor can work in either of two ways. It can issue the multiply twice, once to read the low word and once to read the high word. It can also issue one multiply with the write enable set and fetch the high word later from the holding register. A build parameter selects a reduced array that keeps only the low word. In that array the adder of each later stage is one bit narrower than the one before. The result port is a plain combinational bus with no handshake, because a processor reads it in the same cycle it drives the operands.

Top module: `hwmul_unit`

## Requirements
- R1: With op code 2'b00 the result equals the low W bits of the unsigned product of the two operands, in the same cycle as the operands.
- R2: With op code 2'b01 the result equals the product shifted right by W bits (the high word), in the same cycle.
- R3: With op code 2'b10 the result equals the held high word, whatever the operands are.
- R4: At a rising clock edge where the write enable is high and the op code is 2'b00 or 2'b01, the held register takes the high word of the current product.
- R5: The held register keeps its value at every edge where the write enable is low or the op code is 2'b10 or 2'b11.
- R6: While the active-low reset is low, the held register is zero.
- R7: With op code 2'b11 the result is zero.
- R8: A zero operand gives zero in both words, and all-ones times all-ones gives high word 0xFFFE and low word 0x0001 for W=16.
- R9: With FULL_PRODUCT=0 the low word stays correct, op code 2'b01 returns zero, and a load stores zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the held high-word register |
| rst_ni | input | 1 | Asynchronous active-low reset of the held register |
| opnd_a_i | input | W | Multiplicand |
| opnd_b_i | input | W | Multiplier |
| op_sel_i | input | 2 | Op code: 00 low word, 01 high word, 10 read held high word, 11 zero |
| wr_en_i | input | 1 | Load the high word into the held register on a multiply op |
| result_o | output | W | Selected result word |

## Verification
The only internal state is the held high word, so a wrong state shows up only on the first read with op code 2'b10. A load that is skipped, missed or taken when it should not be shows as a stale or wrong value one edge later. A fault inside a stage cell corrupts product bit k and every bit above it. That fault shows at once on the low or high read for any operand pair that exercises that stage. For this reason the bench sweeps every operand pair of a narrow array and adds corner and pseudo-random pairs at full width.

// File: rtl/hwmul_pkg.sv
`timescale 1ns/1ps
package hwmul_pkg;

  typedef enum logic [1:0] {
    OP_MUL_LO  = 2'b00,
    OP_MUL_HI  = 2'b01,
    OP_READ_HI = 2'b10,
    OP_NONE    = 2'b11
  } mul_op_e;

  function automatic logic op_is_multiply(input mul_op_e op);
    return (op == OP_MUL_LO) || (op == OP_MUL_HI);
  endfunction

endpackage

// File: rtl/hwmul_stage_cell.sv
`timescale 1ns/1ps
// One array stage: gate the multiplicand with one multiplier bit and add it
// to the incoming partial sum. KEEP_CARRY selects whether the carry out is kept.
module hwmul_stage_cell #(
  parameter int ADD_W      = 16,
  parameter int KEEP_CARRY = 1
) (
  input  logic [ADD_W-1:0]            mcand_i,
  input  logic                        mbit_i,
  input  logic [ADD_W-1:0]            addend_i,
  output logic [ADD_W+KEEP_CARRY-1:0] sum_o
);
  logic [ADD_W-1:0] gated;

  assign gated = mcand_i & {ADD_W{mbit_i}};

  if (KEEP_CARRY != 0) begin : g_carry
    assign sum_o = {1'b0, addend_i} + {1'b0, gated};
  end else begin : g_trunc
    assign sum_o = addend_i + gated;
  end
endmodule

// File: rtl/hwmul_array.sv
`timescale 1ns/1ps
// Combinational array of stage cells. FULL_PRODUCT=1 builds full-width stages
// and a 2W-bit product. FULL_PRODUCT=0 builds stages that narrow by one bit each
// and keeps only the low word.
module hwmul_array #(
  parameter int W            = 16,
  parameter int FULL_PRODUCT = 1
) (
  input  logic [W-1:0]   opnd_a_i,
  input  logic [W-1:0]   opnd_b_i,
  output logic [2*W-1:0] prod_o
);
  if (FULL_PRODUCT != 0) begin : g_full_arr
    logic [W-1:0] lo_bits;

    for (genvar k = 0; k < W; k++) begin : g_stg
      logic [W:0] acc;
      if (k == 0) begin : g_first
        assign acc = {1'b0, opnd_a_i & {W{opnd_b_i[0]}}};
      end else begin : g_next
        hwmul_stage_cell #(
          .ADD_W      (W),
          .KEEP_CARRY (1)
        ) cell_i (
          .mcand_i  (opnd_a_i),
          .mbit_i   (opnd_b_i[k]),
          .addend_i (g_stg[k-1].acc[W:1]),
          .sum_o    (acc)
        );
      end
      assign lo_bits[k] = acc[0];
    end

    assign prod_o = {g_stg[W-1].acc[W:1], lo_bits};

  end else begin : g_low_arr
    for (genvar k = 0; k < W; k++) begin : g_stg
      logic [W-1:0] run;
      if (k == 0) begin : g_first
        assign run = opnd_a_i & {W{opnd_b_i[0]}};
      end else begin : g_next
        localparam int NW = W - k;
        hwmul_stage_cell #(
          .ADD_W      (NW),
          .KEEP_CARRY (0)
        ) cell_i (
          .mcand_i  (opnd_a_i[NW-1:0]),
          .mbit_i   (opnd_b_i[k]),
          .addend_i (g_stg[k-1].run[W-1:k]),
          .sum_o    (run[W-1:k])
        );
        assign run[k-1:0] = g_stg[k-1].run[k-1:0];
      end
    end

    assign prod_o = {{W{1'b0}}, g_stg[W-1].run};
  end
endmodule

// File: rtl/hwmul_hi_latch.sv
`timescale 1ns/1ps
module hwmul_hi_latch #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (load_i) begin
      q_o <= d_i;
    end
  end
endmodule

// File: rtl/hwmul_result_sel.sv
`timescale 1ns/1ps
module hwmul_result_sel
  import hwmul_pkg::*;
#(
  parameter int W = 16
) (
  input  mul_op_e      op_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] held_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_MUL_LO:  res_o = lo_i;
      OP_MUL_HI:  res_o = hi_i;
      OP_READ_HI: res_o = held_i;
      default:    res_o = '0;
    endcase
  end
endmodule

// File: rtl/hwmul_unit.sv
`timescale 1ns/1ps
module hwmul_unit
  import hwmul_pkg::*;
#(
  parameter int W            = 16,
  parameter int FULL_PRODUCT = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] opnd_a_i,
  input  logic [W-1:0] opnd_b_i,
  input  logic [1:0]   op_sel_i,
  input  logic         wr_en_i,
  output logic [W-1:0] result_o
);
  mul_op_e        op;
  logic [2*W-1:0] prod_w;
  logic [W-1:0]   hi_q;
  logic           hi_load;

  assign op      = mul_op_e'(op_sel_i);
  assign hi_load = wr_en_i && op_is_multiply(op);

  hwmul_array #(
    .W            (W),
    .FULL_PRODUCT (FULL_PRODUCT)
  ) array_i (
    .opnd_a_i (opnd_a_i),
    .opnd_b_i (opnd_b_i),
    .prod_o   (prod_w)
  );

  hwmul_hi_latch #(
    .W (W)
  ) hi_latch_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (hi_load),
    .d_i    (prod_w[2*W-1:W]),
    .q_o    (hi_q)
  );

  hwmul_result_sel #(
    .W (W)
  ) sel_i (
    .op_i   (op),
    .lo_i   (prod_w[W-1:0]),
    .hi_i   (prod_w[2*W-1:W]),
    .held_i (hi_q),
    .res_o  (result_o)
  );
endmodule

// File: rtl/hwmul_unit_chk.sv
`timescale 1ns/1ps
module hwmul_unit_chk #(
  parameter int W    = 16,
  parameter int FULL = 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [W-1:0]   opnd_a_i,
  input logic [W-1:0]   opnd_b_i,
  input logic [1:0]     op_sel_i,
  input logic           wr_en_i,
  input logic [W-1:0]   result_o,
  input logic [2*W-1:0] prod_i,
  input logic [W-1:0]   hi_q_i
);
  logic is_mul;
  assign is_mul = (op_sel_i == 2'b00) || (op_sel_i == 2'b01);

  // R4
  hi_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && is_mul) |=> (hi_q_i == $past(prod_i[2*W-1:W])));

  // R5
  hi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && is_mul) |=> $stable(hi_q_i));

  // R3
  read_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_sel_i == 2'b10) |-> (result_o == hi_q_i));

  // R7
  op_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_sel_i == 2'b11) |-> (result_o == '0));

  // R8
  zero_opnd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((opnd_a_i == '0) || (opnd_b_i == '0)) |-> (prod_i == '0));

  // R1
  lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_i[0] == (opnd_a_i[0] & opnd_b_i[0]));

  if (FULL == 0) begin : g_low_only
    // R9
    low_only_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prod_i[2*W-1:W] == '0);
  end
endmodule

bind hwmul_unit hwmul_unit_chk #(
  .W    (W),
  .FULL (FULL_PRODUCT)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .opnd_a_i (opnd_a_i),
  .opnd_b_i (opnd_b_i),
  .op_sel_i (op_sel_i),
  .wr_en_i  (wr_en_i),
  .result_o (result_o),
  .prod_i   (prod_w),
  .hi_q_i   (hi_q)
);

// File: tb/hwmul_unit_tb_top.sv
`timescale 1ns/1ps
module hwmul_unit_tb_top;
  localparam int WB = 16;
  localparam int WS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [WB-1:0] a16 = '0, b16 = '0, res16;
  logic [1:0]    op16 = 2'b11;
  logic          we16 = 1'b0;

  logic [WS-1:0] a5 = '0, b5 = '0, res_f5, res_l5;
  logic [1:0]    op5 = 2'b11;
  logic          we5 = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  hwmul_unit #(.W(WB), .FULL_PRODUCT(1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .opnd_a_i(a16), .opnd_b_i(b16),
    .op_sel_i(op16), .wr_en_i(we16), .result_o(res16));

  hwmul_unit #(.W(WS), .FULL_PRODUCT(1)) dut_f5_i (
    .clk_i(clk), .rst_ni(rst_n), .opnd_a_i(a5), .opnd_b_i(b5),
    .op_sel_i(op5), .wr_en_i(we5), .result_o(res_f5));

  hwmul_unit #(.W(WS), .FULL_PRODUCT(0)) dut_l5_i (
    .clk_i(clk), .rst_ni(rst_n), .opnd_a_i(a5), .opnd_b_i(b5),
    .op_sel_i(op5), .wr_en_i(we5), .result_o(res_l5));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Combinational low/high/zero check of the wide unit
  task automatic wide_case(input logic [15:0] x, input logic [15:0] y);
    logic [31:0] p;
    p = {16'h0, x} * {16'h0, y};
    a16 = x; b16 = y;
    op16 = 2'b00; #1; chk("R1 low word", res16, p[15:0]);
    op16 = 2'b01; #1; chk("R2 high word", res16, p[31:16]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    logic [31:0] pw;
    logic [9:0]  ps;
    seed = 32'h1BADF00D;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R6: held register is zero in reset and just after release
    op16 = 2'b10; op5 = 2'b10; #1;
    chk("R6 reset held word", res16, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 held word after release", res16, 16'h0);
    chk("R6 held word after release (narrow)", {11'h0, res_f5}, 16'h0);

    // R8 corners
    a16 = 16'h0; b16 = 16'hBEEF;
    op16 = 2'b00; #1; chk("R8 zero a low", res16, 16'h0);
    op16 = 2'b01; #1; chk("R8 zero a high", res16, 16'h0);
    a16 = 16'hCAFE; b16 = 16'h0;
    op16 = 2'b00; #1; chk("R8 zero b low", res16, 16'h0);
    op16 = 2'b01; #1; chk("R8 zero b high", res16, 16'h0);
    a16 = 16'hFFFF; b16 = 16'hFFFF;
    op16 = 2'b00; #1; chk("R8 ones low", res16, 16'h0001);
    op16 = 2'b01; #1; chk("R8 ones high", res16, 16'hFFFE);
    // R7
    op16 = 2'b11; #1; chk("R7 op 11 zero", res16, 16'h0);

    wide_case(16'h0001, 16'hFFFF);
    wide_case(16'h8000, 16'h8000);
    wide_case(16'h1234, 16'h5678);
    wide_case(16'hFFFF, 16'h0002);

    // R1/R2 pseudo-random sweep
    for (int i = 0; i < 4000; i++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      wide_case(seed[15:0], seed[31:16]);
    end

    // R4: load via op 01, then read with other operands
    @(negedge clk);
    a16 = 16'h1234; b16 = 16'h5678; op16 = 2'b01; we16 = 1'b1;
    pw = 32'h1234 * 32'h5678;
    @(negedge clk);
    we16 = 1'b0; a16 = 16'hFFFF; b16 = 16'hFFFF; op16 = 2'b10; #1;
    chk("R4 load via op 01 / R3 read ignores operands", res16, pw[31:16]);
    // R5: write enable low on multiply
    op16 = 2'b01; we16 = 1'b0;
    @(negedge clk);
    op16 = 2'b10; #1; chk("R5 no load when wr_en low", res16, pw[31:16]);
    // R5: wr_en high with op 10
    we16 = 1'b1;
    @(negedge clk);
    #1; chk("R5 no load on op 10", res16, pw[31:16]);
    // R5: wr_en high with op 11
    op16 = 2'b11;
    @(negedge clk);
    we16 = 1'b0; op16 = 2'b10; #1; chk("R5 no load on op 11", res16, pw[31:16]);
    // R4: load via op 00
    a16 = 16'hFFFF; b16 = 16'hFFFF; op16 = 2'b00; we16 = 1'b1;
    @(negedge clk);
    we16 = 1'b0; a16 = 16'h0; op16 = 2'b10; #1;
    chk("R4 load via op 00", res16, 16'hFFFE);

    // R1/R2/R9 exhaustive narrow sweep
    for (int x = 0; x < 32; x++) begin
      for (int y = 0; y < 32; y++) begin
        ps = 10'(x * y);
        a5 = 5'(x); b5 = 5'(y);
        op5 = 2'b00; #1;
        chk("R1 narrow low", {11'h0, res_f5}, {11'h0, ps[4:0]});
        chk("R9 low-only low word", {11'h0, res_l5}, {11'h0, ps[4:0]});
        op5 = 2'b01; #1;
        chk("R2 narrow high", {11'h0, res_f5}, {11'h0, ps[9:5]});
        chk("R9 low-only high zero", {11'h0, res_l5}, 16'h0);
      end
    end

    // R9: load in low-only variant stores zero; R4 on the narrow full unit
    @(negedge clk);
    a5 = 5'h1F; b5 = 5'h1F; op5 = 2'b00; we5 = 1'b1;
    @(negedge clk);
    we5 = 1'b0; op5 = 2'b10; #1;
    chk("R9 low-only held word zero", {11'h0, res_l5}, 16'h0);
    chk("R4 narrow held word", {11'h0, res_f5}, 16'h001E);

    // R6: reset clears a loaded register
    rst_n = 1'b0; #1;
    chk("R6 async reset clears", res16, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule